// File: doc/BRIEF.md
# Paged RAM Write-Protect Controller

This block sits between a 32-bit processor-side request port and a small on-chip RAM split into two 16 KB pages, starting at 0xFFF80000 (page 0) and 0xFFF84000 (page 1). An 8-bit control register holds one write-enable bit per page. Stores to a page whose bit is clear are dropped without any error, and loads from either page are always served. Accesses that hit neither page nor the control register get a one-cycle error pulse instead of an acknowledge.

Each page keeps its last accepted store in a single-entry deferred buffer. That buffer reaches the storage array only when a later load or store goes to the same page. Once a page is protected, its pending entry is thrown away. Software therefore has to touch every page before it clears that page's enable bit. A newly written enable value governs RAM accesses only from the second cycle after the register write.

There are two reset inputs. The cold reset (power-on or deep-standby exit) reinitialises the register. The warm reset (manual reset or software-standby exit) leaves the register as it is. Both resets discard the pending buffers without committing them. RAM accesses are always whole 32-bit words whatever the size code. Each page is backed by `WORDS_PER_PAGE` words, indexed by the word address bits within the page.

Top module: `wpram_guard`

## Requirements
- R1: While `rst_por` is high and afterwards, the control register reads 0xFF and both pages accept stores.
- R2: `rst_warm` leaves the control register unchanged and discards both pending buffers without writing them to the array.
- R3: A byte read of the control register returns the register on `rdata[7:0]` with `rdata[31:8]` zero. Bits 7..2 always read 1 whatever was written to them. Only bits 1..0 are stored from `wdata[1:0]` on a byte write. Size code 0 means byte, 1 halfword, 2 word.
- R4: A halfword or word access (size code not 0) to the control register is acknowledged, leaves the register unchanged, and a read returns 0xFFFFFFFF.
- R5: Bit 1 enables stores to 0xFFF84000..0xFFF87FFF and bit 0 enables stores to 0xFFF80000..0xFFF83FFF. A store to a page whose bit is 0 is acknowledged but changes no stored word.
- R6: Loads from either page are served whatever the enable bits. A load returns the pending buffer data when it targets the buffered word of an enabled page.
- R7: A store to an enabled page is held in that page's buffer. The held word is written to the array when the next load or store to that page is accepted.
- R8: A pending store on a page whose effective enable is 0 is discarded and never reaches the array.
- R9: A new enable value governs RAM accesses from the second request cycle after the register write. The access in the cycle right after the write still uses the previous value.
- R10: An access outside both pages and the register address gets `err` high for exactly one cycle, the cycle after the request, with no `ack` and `rdata` zero.
- R11: Every accepted request gets `ack` in the following cycle only. `ack` and `err` are never high together, write responses carry `rdata` zero, and both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Cold reset, active high, synchronous: reinitialises the register, clears buffers |
| rst_warm | input | 1 | Warm reset, active high, synchronous: clears buffers only |
| req | input | 1 | Request valid for one cycle |
| wr | input | 1 | 1 store, 0 load |
| size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store data |
| ack | output | 1 | Request accepted, one cycle after `req` |
| err | output | 1 | Unmapped address, one cycle after `req` |
| rdata | output | 32 | Load data, valid with `ack` |

## Verification
All responses (`ack`, `err` and `rdata`) appear in the cycle after the request. The bench drives a request on a falling edge, lets one rising edge pass, and samples the outputs on the next falling edge, before the next request takes over. A register write changes what a read returns in the very next cycle. Its effect on RAM stores starts one request later, so directed sequences put a store in each of those two slots and read both back. Pending-buffer effects are visible only through a later load, so every such check reads the word back after the triggering access, the disable or the warm reset.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_CTL  = 2'd1,
      TGT_RAM  = 2'd2
   } tgt_e;

   function automatic int unsigned width_of(input int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/wpg_addr_decode.sv
module wpg_addr_decode
   import wpg_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned DATA_W         = 32,
   parameter logic [ADDR_W-1:0] RAM_BASE = 32'hFFF8_0000,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hFFFE_0C00,
   parameter int unsigned PAGE_BYTES     = 16384,
   parameter int unsigned PAGES          = 2,
   parameter int unsigned WORDS_PER_PAGE = 256,
   localparam int unsigned PG_W          = width_of(PAGES),
   localparam int unsigned IDX_W         = width_of(WORDS_PER_PAGE)
)(
   input  logic [ADDR_W-1:0] addr,
   output tgt_e              tgt,
   output logic [PG_W-1:0]   page,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned PAGE_SHIFT = $clog2(PAGE_BYTES);
   localparam int unsigned OFS_W      = $clog2(DATA_W / 8);
   localparam logic [ADDR_W:0] SPAN   = (ADDR_W+1)'(PAGES) << PAGE_SHIFT;

   // offset from the RAM base; an address below the base wraps to a value
   // with the top bit set and so falls outside the span
   logic [ADDR_W:0] ofs;
   logic            in_ram;

   assign ofs    = {1'b0, addr} - {1'b0, RAM_BASE};
   assign in_ram = (ofs < SPAN);
   assign idx    = ofs[OFS_W +: IDX_W];

   generate
      if (PAGES > 1) begin : g_multi
         assign page = ofs[PAGE_SHIFT +: PG_W];
      end else begin : g_single
         assign page = '0;
      end
   endgenerate

   always_comb begin
      if (addr == CTRL_ADDR)
         tgt = TGT_CTL;
      else if (in_ram)
         tgt = TGT_RAM;
      else
         tgt = TGT_NONE;
   end

endmodule

// File: rtl/wpg_ctl_reg.sv
module wpg_ctl_reg #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned PAGES = 2
)(
   input  logic             clk,
   input  logic             rst_por,
   input  logic             wr_stb,
   input  logic [PAGES-1:0] wr_bits,
   output logic [REG_W-1:0] ctl_val,
   output logic [PAGES-1:0] en_eff
);
   logic [PAGES-1:0] en_q;

   // only the cold reset touches the stored enables
   always_ff @(posedge clk) begin
      if (rst_por)
         en_q <= '1;
      else if (wr_stb)
         en_q <= wr_bits;
   end

   // the enable seen by the RAM path trails the register by one cycle
   always_ff @(posedge clk) begin
      if (rst_por)
         en_eff <= '1;
      else
         en_eff <= en_q;
   end

   generate
      if (REG_W > PAGES) begin : g_pad
         assign ctl_val = {{(REG_W-PAGES){1'b1}}, en_q};
      end else begin : g_full
         assign ctl_val = en_q;
      end
   endgenerate

endmodule

// File: rtl/wpg_page_bank.sv
module wpg_page_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 256,
   parameter int unsigned IDX_W  = 8
)(
   input  logic              clk,
   input  logic              flush,
   input  logic              en,
   input  logic              acc,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [WORDS];
   logic              buf_v;
   logic [IDX_W-1:0]  buf_idx;
   logic [DATA_W-1:0] buf_dat;
   logic              live;
   logic              drain;
   logic              hit;

   assign live  = buf_v && en;
   assign drain = acc && live;
   assign hit   = live && (buf_idx == idx);

   always_ff @(posedge clk) begin
      if (drain && !flush)
         mem[buf_idx] <= buf_dat;
   end

   always_ff @(posedge clk) begin
      if (acc && !wr)
         rd_data <= hit ? buf_dat : mem[idx];
   end

   always_ff @(posedge clk) begin
      if (flush || !en) begin
         buf_v <= 1'b0;
      end else if (acc && wr) begin
         buf_v   <= 1'b1;
         buf_idx <= idx;
         buf_dat <= wdata;
      end else if (acc) begin
         buf_v <= 1'b0;
      end
   end

endmodule

// File: rtl/wpram_guard.sv
module wpram_guard
   import wpg_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned REG_W           = 8,
   parameter int unsigned PAGES           = 2,
   parameter int unsigned PAGE_BYTES      = 16384,
   parameter int unsigned WORDS_PER_PAGE  = 256,
   parameter logic [ADDR_W-1:0] RAM_BASE  = 32'hFFF8_0000,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hFFFE_0C00
)(
   input  logic              clk,
   input  logic              rst_por,
   input  logic              rst_warm,
   input  logic              req,
   input  logic              wr,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic              err,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned PG_W  = width_of(PAGES);
   localparam int unsigned IDX_W = width_of(WORDS_PER_PAGE);

   initial begin
      assert (PAGES >= 1 && PAGES <= REG_W)
         else $error("PAGES must lie between 1 and REG_W");
      assert (DATA_W >= REG_W && (DATA_W % 8) == 0)
         else $error("DATA_W must be a byte multiple no narrower than REG_W");
      assert ((1 << $clog2(PAGE_BYTES)) == PAGE_BYTES)
         else $error("PAGE_BYTES must be a power of two");
      assert (WORDS_PER_PAGE * (DATA_W / 8) <= PAGE_BYTES)
         else $error("page storage exceeds page window");
   end

   acc_size_e         sz;
   tgt_e              tgt;
   logic [PG_W-1:0]   page;
   logic [IDX_W-1:0]  idx;
   logic [REG_W-1:0]  ctl_val;
   logic [PAGES-1:0]  en_eff;
   logic              ctl_wr;
   logic              flush;
   logic [DATA_W-1:0] bank_rd [PAGES];

   logic              ack_q, err_q, rd_q;
   tgt_e              tgt_q;
   logic [PG_W-1:0]   page_q;
   logic [DATA_W-1:0] ctl_rd_q;

   assign sz     = acc_size_e'(size);
   assign flush  = rst_por | rst_warm;
   assign ctl_wr = req && wr && (tgt == TGT_CTL) && (sz == SZ_BYTE);

   wpg_addr_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BASE(RAM_BASE), .CTRL_ADDR(CTRL_ADDR),
      .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .WORDS_PER_PAGE(WORDS_PER_PAGE)
   ) u_dec (
      .addr(addr), .tgt(tgt), .page(page), .idx(idx)
   );

   wpg_ctl_reg #(.REG_W(REG_W), .PAGES(PAGES)) u_ctl (
      .clk(clk), .rst_por(rst_por), .wr_stb(ctl_wr), .wr_bits(wdata[PAGES-1:0]),
      .ctl_val(ctl_val), .en_eff(en_eff)
   );

   generate
      for (genvar p = 0; p < PAGES; p++) begin : g_bank
         logic sel;
         assign sel = req && (tgt == TGT_RAM) && (page == PG_W'(p));
         wpg_page_bank #(.DATA_W(DATA_W), .WORDS(WORDS_PER_PAGE), .IDX_W(IDX_W)) u_bank (
            .clk(clk), .flush(flush), .en(en_eff[p]), .acc(sel), .wr(wr),
            .idx(idx), .wdata(wdata), .rd_data(bank_rd[p])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (flush) begin
         ack_q    <= 1'b0;
         err_q    <= 1'b0;
         rd_q     <= 1'b0;
         tgt_q    <= TGT_NONE;
         page_q   <= '0;
         ctl_rd_q <= '0;
      end else begin
         ack_q    <= req && (tgt != TGT_NONE);
         err_q    <= req && (tgt == TGT_NONE);
         rd_q     <= req && !wr && (tgt != TGT_NONE);
         tgt_q    <= tgt;
         page_q   <= page;
         ctl_rd_q <= (sz == SZ_BYTE) ? DATA_W'(ctl_val) : '1;
      end
   end

   always_comb begin
      if (!rd_q)
         rdata = '0;
      else if (tgt_q == TGT_CTL)
         rdata = ctl_rd_q;
      else
         rdata = bank_rd[page_q];
   end

   assign ack = ack_q;
   assign err = err_q;

endmodule

// File: rtl/wpram_guard_chk.sv
module wpram_guard_chk #(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned REG_W           = 8,
   parameter int unsigned PAGES           = 2,
   parameter int unsigned PAGE_BYTES      = 16384,
   parameter logic [ADDR_W-1:0] RAM_BASE  = 32'hFFF8_0000,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hFFFE_0C00
)(
   input logic              clk,
   input logic              rst_por,
   input logic              rst_warm,
   input logic              req,
   input logic              wr,
   input logic [1:0]        size,
   input logic [ADDR_W-1:0] addr,
   input logic              ack,
   input logic              err,
   input logic [DATA_W-1:0] rdata,
   input logic [REG_W-1:0]  ctl_val
);
   localparam logic [ADDR_W:0] LIMIT = {1'b0, RAM_BASE} + ((ADDR_W+1)'(PAGES) << $clog2(PAGE_BYTES));

   logic mapped;
   logic ctl_hit;
   assign ctl_hit = (addr == CTRL_ADDR);
   assign mapped  = ctl_hit ||
                    (({1'b0, addr} >= {1'b0, RAM_BASE}) && ({1'b0, addr} < LIMIT));

   assert_por_value_R1: assert property (@(posedge clk) disable iff (rst_warm)
      rst_por |=> (ctl_val == '1));

   assert_warm_keep_R2: assert property (@(posedge clk) disable iff (rst_por)
      rst_warm |=> $stable(ctl_val));

   assert_reserved_ones_R3: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
      (req && !wr && ctl_hit && size == 2'd0) |=>
         (rdata[REG_W-1:PAGES] == '1) && (rdata[DATA_W-1:REG_W] == '0));

   assert_wide_no_change_R4: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
      (req && ctl_hit && size != 2'd0) |=> (ctl_val == $past(ctl_val)));

   assert_wide_read_ones_R4: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
      (req && !wr && ctl_hit && size != 2'd0) |=> (rdata == '1));

   assert_unmapped_err_R10: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
      (req && !mapped) |=> (err && !ack && rdata == '0));

   assert_mapped_ack_R11: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
      (req && mapped) |=> (ack && !err));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
      !req |=> (!ack && !err));

   assert_write_rdata_zero_R11: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
      (req && wr) |=> (rdata == '0));

endmodule

bind wpram_guard wpram_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .PAGES(PAGES),
   .PAGE_BYTES(PAGE_BYTES), .RAM_BASE(RAM_BASE), .CTRL_ADDR(CTRL_ADDR)
) u_chk (.*);

// File: tb/wpram_guard_test.sv
module wpram_guard_test;
   localparam logic [31:0] BASE = 32'hFFF8_0000;
   localparam logic [31:0] CTL  = 32'hFFFE_0C00;

   logic clk = 1'b0;
   logic rst_por = 1'b1, rst_warm = 1'b0;
   logic req = 1'b0, wr = 1'b0;
   logic [1:0]  size = 2'd0;
   logic [31:0] addr = '0, wdata = '0;
   logic ack, err;
   logic [31:0] rdata;

   int total = 0, bad = 0;
   bit finished = 0;

   // bench model of the requirements
   logic [31:0] m_mem [2][16];
   logic        m_bv [2];
   logic [3:0]  m_bi [2];
   logic [31:0] m_bd [2];
   logic [1:0]  m_reg, m_eff;

   wpram_guard uut (
      .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm), .req(req), .wr(wr),
      .size(size), .addr(addr), .wdata(wdata), .ack(ack), .err(err), .rdata(rdata)
   );

   always #10 clk = ~clk;

   function automatic logic [31:0] ram_addr(input int pg, input int ix);
      return BASE + 32'(pg) * 32'h4000 + 32'(ix) * 4;
   endfunction

   task automatic model_step(input logic r, input logic w, input logic [1:0] s,
                             input logic [31:0] a, input logic [31:0] d,
                             output logic ea, output logic ee, output logic [31:0] er);
      logic [1:0] en_old, reg_old;
      int p, ix;
      en_old = m_eff; reg_old = m_reg;
      ea = 0; ee = 0; er = '0;
      if (r) begin
         if (a == CTL) begin
            ea = 1;
            if (!w) er = (s == 2'd0) ? {24'h0, 6'h3F, reg_old} : 32'hFFFF_FFFF;
            else if (s == 2'd0) m_reg = d[1:0];
         end else if (a >= BASE && a < BASE + 32'h8000) begin
            ea = 1;
            p  = int'(a[14]);
            ix = int'(a[5:2]);
            if (en_old[p]) begin
               if (w) begin
                  if (m_bv[p]) m_mem[p][m_bi[p]] = m_bd[p];
                  m_bv[p] = 1; m_bi[p] = 4'(ix); m_bd[p] = d;
               end else begin
                  er = (m_bv[p] && m_bi[p] == 4'(ix)) ? m_bd[p] : m_mem[p][ix];
                  if (m_bv[p]) m_mem[p][m_bi[p]] = m_bd[p];
                  m_bv[p] = 0;
               end
            end else if (!w) begin
               er = m_mem[p][ix];
            end
         end else begin
            ee = 1;
         end
      end
      for (int q = 0; q < 2; q++) if (!en_old[q]) m_bv[q] = 0;
      m_eff = reg_old;
   endtask

   task automatic check(input string tag, input logic ea, input logic ee, input logic [31:0] er);
      total++;
      if (ack !== ea || err !== ee || rdata !== er) begin
         bad++;
         $display("FAIL %s: ack=%b err=%b rdata=%h expected ack=%b err=%b rdata=%h",
                  tag, ack, err, rdata, ea, ee, er);
      end
   endtask

   task automatic op(input logic r, input logic w, input logic [1:0] s,
                     input logic [31:0] a, input logic [31:0] d, input string tag);
      logic ea, ee;
      logic [31:0] er;
      req = r; wr = w; size = s; addr = a; wdata = d;
      model_step(r, w, s, a, d, ea, ee, er);
      @(posedge clk);
      @(negedge clk);
      req = 0;
      check(tag, ea, ee, er);
   endtask

   task automatic do_reset(input bit cold);
      req = 0;
      if (cold) rst_por = 1; else rst_warm = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_por = 0; rst_warm = 0;
      for (int q = 0; q < 2; q++) m_bv[q] = 0;
      if (cold) m_reg = 2'b11;
      m_eff = m_reg;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 2; p++) for (int i = 0; i < 16; i++) m_mem[p][i] = '0;
      void'($urandom(32'd7321));
      @(negedge clk);
      do_reset(1'b1);

      // R11 reset state
      check("R11 idle after reset", 1'b0, 1'b0, 32'h0);
      // R1 R3 register after cold reset
      op(1, 0, 2'd0, CTL, 0, "R1 register reads FF");

      // fill both pages, then drain
      for (int p = 0; p < 2; p++)
         for (int i = 0; i < 16; i++)
            op(1, 1, 2'd2, ram_addr(p, i), 32'hA000_0000 | (p << 8) | i, "R1 pages writable");
      op(1, 0, 2'd2, ram_addr(0, 15), 0, "R6 read pending word");
      op(1, 0, 2'd2, ram_addr(1, 15), 0, "R6 read pending word");

      // R7 commit on next access, R6 buffer hit
      op(1, 1, 2'd2, ram_addr(0, 3), 32'h1111_3333, "R7 store");
      op(1, 1, 2'd2, ram_addr(0, 4), 32'h2222_4444, "R7 store commits prior");
      op(1, 0, 2'd2, ram_addr(0, 3), 0, "R7 committed word");
      op(1, 0, 2'd2, ram_addr(0, 4), 0, "R6 read after commit");
      op(1, 1, 2'd2, ram_addr(1, 9), 32'h5A5A_0909, "R6 store");
      op(1, 0, 2'd2, ram_addr(1, 9), 0, "R6 buffer hit");

      // R5 page 1 protected, page 0 open
      op(1, 1, 2'd0, CTL, 32'h0000_00FD, "R5 disable page1");
      op(0, 0, 2'd0, 0, 0, "R11 idle");
      op(1, 1, 2'd2, ram_addr(1, 2), 32'hDEAD_0002, "R5 store to protected page");
      op(1, 0, 2'd2, ram_addr(1, 2), 0, "R5 protected word unchanged");
      op(1, 1, 2'd2, ram_addr(0, 2), 32'hBEEF_0002, "R5 store to open page");
      op(1, 0, 2'd2, ram_addr(0, 2), 0, "R5 open page updated");

      // R3 reserved bits
      op(1, 1, 2'd0, CTL, 32'h0000_0000, "R3 write zero");
      op(1, 0, 2'd0, CTL, 0, "R3 reserved read ones");

      // R4 wide accesses
      op(1, 1, 2'd2, CTL, 32'hFFFF_FFFF, "R4 word write ignored");
      op(1, 1, 2'd1, CTL, 32'hFFFF_FFFF, "R4 half write ignored");
      op(1, 0, 2'd2, CTL, 0, "R4 word read");
      op(1, 0, 2'd1, CTL, 0, "R4 half read");
      op(1, 0, 2'd0, CTL, 0, "R4 register unchanged");

      // R9 enable takes effect one cycle late
      op(1, 1, 2'd0, CTL, 32'h0000_0003, "R9 enable both");
      op(1, 1, 2'd2, ram_addr(0, 5), 32'h0000_D0D0, "R9 store uses old enable");
      op(1, 1, 2'd2, ram_addr(0, 6), 32'h0000_E0E0, "R9 store uses new enable");
      op(1, 0, 2'd2, ram_addr(0, 5), 0, "R9 early store dropped");
      op(1, 0, 2'd2, ram_addr(0, 6), 0, "R9 later store kept");

      // R8 pending dropped on disable
      op(1, 1, 2'd2, ram_addr(1, 7), 32'hF0F0_0007, "R8 store pending");
      op(1, 1, 2'd0, CTL, 32'h0000_0001, "R8 disable page1");
      op(0, 0, 2'd0, 0, 0, "R11 idle");
      op(0, 0, 2'd0, 0, 0, "R11 idle");
      op(1, 1, 2'd0, CTL, 32'h0000_0003, "R8 re-enable");
      op(0, 0, 2'd0, 0, 0, "R11 idle");
      op(1, 0, 2'd2, ram_addr(1, 7), 0, "R8 pending lost");

      // R2 warm reset
      op(1, 1, 2'd0, CTL, 32'h0000_0001, "R2 set register");
      op(1, 1, 2'd2, ram_addr(0, 8), 32'h6666_0008, "R2 store pending");
      do_reset(1'b0);
      op(1, 0, 2'd0, CTL, 0, "R2 register kept");
      op(1, 0, 2'd2, ram_addr(0, 8), 0, "R2 pending discarded");

      // R1 cold reset again
      do_reset(1'b1);
      op(1, 0, 2'd0, CTL, 0, "R1 register reinit");
      op(1, 1, 2'd2, ram_addr(1, 1), 32'h7777_0001, "R1 page1 writable");
      op(1, 0, 2'd2, ram_addr(1, 1), 0, "R1 page1 store visible");

      // R10 unmapped
      op(1, 0, 2'd2, 32'hFFF8_8000, 0, "R10 just above pages");
      op(1, 1, 2'd2, 32'hFFF7_FFFC, 32'h1, "R10 just below pages");
      op(1, 0, 2'd0, CTL + 4, 0, "R10 next to register");
      op(1, 0, 2'd2, 32'h0000_0000, 0, "R10 address zero");

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         int unsigned k;
         logic [31:0] a, d;
         k = $urandom_range(99);
         a = ram_addr(int'($urandom_range(1)), int'($urandom_range(15)));
         d = $urandom;
         if (k < 35)       op(1, 1, 2'd2, a, d, "R7 random store");
         else if (k < 65)  op(1, 0, 2'($urandom_range(2)), a, 0, "R6 random load");
         else if (k < 73)  op(1, 1, 2'd0, CTL, {24'h0, 8'(d | 32'h2 * ($urandom_range(3) != 0))}, "R5 random enable");
         else if (k < 76)  op(1, 1, 2'($urandom_range(1, 3)), CTL, d, "R4 random wide write");
         else if (k < 80)  op(1, 0, 2'($urandom_range(3)), CTL, 0, "R3 random register read");
         else if (k < 85)  op(1, $urandom_range(1) == 1, 2'd2, 32'h1000_0000 | (d & 32'h0000_FFFC), d, "R10 random unmapped");
         else if (k < 99)  op(0, 0, 2'd0, 0, 0, "R11 random idle");
         else begin
            do_reset(1'b0);
            check("R2 random warm reset idle", 1'b0, 1'b0, 32'h0);
         end
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule